// File: doc/BRIEF.md
# Wave Instruction Issue Arbiter

This block chooses which wavefronts issue instructions in a compute unit whose waves are spread evenly over several SIMD units (four by default, each holding ten wave slots). On each clock only the waves resident on one SIMD are candidates. The active SIMD advances by one every cycle in a fixed rotation, so each SIMD is visited once every four cycles. That cadence fits a vector instruction that occupies its SIMD for four cycles.

Each wave slot presents a ready mask with one bit per instruction category, an age value and a stall flag. For every category the arbiter grants the oldest ready, unstalled wave of the active SIMD. Categories are resolved in fixed priority order, and a wave that has already won a category is withheld from all lower ones. No more than a configurable number of non-internal categories (five by default) can issue in one cycle. The internal category (no-op, sleep, wait-count, barrier, priority change) is granted in addition to that limit. Grants and the issue count are registered.

Top module: `wave_issue_arbiter`

## Requirements
- R1: A synchronous reset clears every grant-valid bit and the issue count. The first arbitration after reset is release examines SIMD 0.
- R2: The arbitration in successive cycles examines SIMD 0, 1, 2, 3, 0, and so on. A grant is only given to a wave of the examined SIMD, and its grant carries that SIMD's index.
- R3: Within one category, the ready wave with the largest age value wins.
- R4: When ready waves of one category have equal age, the lowest wave index wins.
- R5: Ready-mask bit c requests category c: 0 vector ALU, 1 scalar ALU or scalar memory read, 2 vector memory, 3 branch or message, 4 local data share, 5 export or global data share, 6 internal. A category with no requester has its grant-valid bit low.
- R6: A single wave is granted at most one category per cycle, even when it is ready in several.
- R7: Categories are resolved in order 0 to 6. A wave that wins a lower-numbered category is withheld from higher-numbered ones, and another ready wave may take those categories instead.
- R8: A wave whose stall input is high is not granted in the cycle it is sampled.
- R9: At most five non-internal categories are granted per cycle. When categories 0 to 4 are all granted, category 5 gets no grant; category 5 on its own is granted normally.
- R10: The internal category (6) is granted independently of the limit in R9.
- R11: The issue count equals the number of granted non-internal categories.
- R12: Grants for inputs present before a clock edge appear after that edge and stay unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_rdy | input | 280 | Ready mask per slot, 7 bits per slot; slot index = simd*10 + wave |
| slot_age | input | 320 | Age per slot, 8 bits per slot; larger is older |
| slot_stall | input | 40 | Stall flag per slot |
| gnt_vld | output | 7 | Grant valid, one bit per category |
| gnt_simd | output | 14 | SIMD index of each category's grant, 2 bits per category |
| gnt_wave | output | 28 | Wave index of each category's grant, 4 bits per category |
| issue_cnt | output | 3 | Number of non-internal grants this cycle |

## Verification
A rotation counter that skips or repeats a SIMD shows up on the next visible grant. Either its reported SIMD index is wrong, or a grant arrives in a cycle whose SIMD holds no ready wave; four cycles of a lone request on one SIMD expose this. A broken masking chain or priority order shows within the same registered cycle. It appears as one wave index in two grant fields, as a lower-priority category taken by the wrong wave, or as an issue count that disagrees with the valid bits. Tie-break, age comparison and stall faults each change a single wave index one cycle after the stimulus.

// File: rtl/wia_pkg.sv
package wia_pkg;
   typedef enum logic [2:0] {
      CAT_VALU     = 3'd0,
      CAT_SCALAR   = 3'd1,
      CAT_VMEM     = 3'd2,
      CAT_BRANCH   = 3'd3,
      CAT_LDS      = 3'd4,
      CAT_EXPORT   = 3'd5,
      CAT_INTERNAL = 3'd6
   } cat_e;

   localparam int NUM_CAT = 7;
   localparam int INT_CAT = int'(CAT_INTERNAL);
endpackage

// File: rtl/wia_rotor.sv
module wia_rotor #(
   parameter int NUM_SIMD = 4,
   localparam int SIMD_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [SIMD_W-1:0] rot
);
   generate
      if ((1 << SIMD_W) == NUM_SIMD) begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst) rot <= '0;
            else     rot <= rot + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst)                                rot <= '0;
            else if (rot == SIMD_W'(NUM_SIMD - 1)) rot <= '0;
            else                                    rot <= rot + 1'b1;
         end
      end
   endgenerate

   // R2
   rot_step_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> int'(rot) == ((int'($past(rot)) + 1) % NUM_SIMD));
endmodule

// File: rtl/wia_oldest_pick.sv
module wia_oldest_pick #(
   parameter int N     = 10,
   parameter int AGE_W = 8,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]       req,
   input  logic [N*AGE_W-1:0] age,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);
   logic [AGE_W-1:0] best;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!found || age[i*AGE_W +: AGE_W] > best)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
            best  = age[i*AGE_W +: AGE_W];
         end
      end
   end
endmodule

// File: rtl/wave_issue_arbiter.sv
module wave_issue_arbiter
   import wia_pkg::*;
#(
   parameter int NUM_SIMD       = 4,
   parameter int WAVES_PER_SIMD = 10,
   parameter int AGE_W          = 8,
   parameter int MAX_ISSUE      = 5,
   localparam int NUM_SLOTS     = NUM_SIMD * WAVES_PER_SIMD,
   localparam int SIMD_W        = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
   localparam int WAVE_W        = (WAVES_PER_SIMD > 1) ? $clog2(WAVES_PER_SIMD) : 1,
   localparam int CNT_W         = $clog2(NUM_CAT)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_SLOTS*NUM_CAT-1:0] slot_rdy,
   input  logic [NUM_SLOTS*AGE_W-1:0]   slot_age,
   input  logic [NUM_SLOTS-1:0]         slot_stall,
   output logic [NUM_CAT-1:0]           gnt_vld,
   output logic [NUM_CAT*SIMD_W-1:0]    gnt_simd,
   output logic [NUM_CAT*WAVE_W-1:0]    gnt_wave,
   output logic [CNT_W-1:0]             issue_cnt
);
   localparam int W = WAVES_PER_SIMD;

   generate
      if (NUM_SIMD < 2 || W < 1 || AGE_W < 1 || MAX_ISSUE < 1 || MAX_ISSUE > NUM_CAT - 1)
      begin : g_bad_cfg
         $error("wave_issue_arbiter: unsupported parameter set");
      end
   endgenerate

   logic [SIMD_W-1:0] rot;

   wia_rotor #(.NUM_SIMD(NUM_SIMD)) u_rotor (
      .clk (clk),
      .rst (rst),
      .rot (rot)
   );

   // gather the slots of the SIMD under examination
   logic [NUM_CAT-1:0][W-1:0] act_rdy;
   logic [W*AGE_W-1:0]        act_age;

   always_comb begin
      int base;
      act_rdy = '0;
      act_age = '0;
      for (int w = 0; w < W; w++) begin
         base = int'(rot) * W + w;
         act_age[w*AGE_W +: AGE_W] = slot_age[base*AGE_W +: AGE_W];
         for (int c = 0; c < NUM_CAT; c++) begin
            act_rdy[c][w] = slot_rdy[base*NUM_CAT + c] & ~slot_stall[base];
         end
      end
   end

   logic [NUM_CAT-1:0]             pick_vld;
   logic [NUM_CAT-1:0][WAVE_W-1:0] pick_wave;

   // priority chain: each category sees the waves not yet taken
   generate
      for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
         logic [W-1:0]     taken_in, taken_out, req;
         logic [CNT_W-1:0] nint_in, nint_out;
         logic             cap_ok, found;
         logic [WAVE_W-1:0] idx;

         if (c == 0) begin : g_head
            assign taken_in = '0;
            assign nint_in  = '0;
         end else begin : g_link
            assign taken_in = g_cat[c-1].taken_out;
            assign nint_in  = g_cat[c-1].nint_out;
         end

         if (c == INT_CAT) begin : g_nolimit
            assign cap_ok = 1'b1;
         end else begin : g_limit
            assign cap_ok = (nint_in < CNT_W'(MAX_ISSUE));
         end

         assign req = act_rdy[c] & ~taken_in & {W{cap_ok}};

         wia_oldest_pick #(.N(W), .AGE_W(AGE_W), .IDX_W(WAVE_W)) u_pick (
            .req   (req),
            .age   (act_age),
            .found (found),
            .idx   (idx)
         );

         assign taken_out    = taken_in | (found ? (W'(1) << idx) : '0);
         assign nint_out     = nint_in + CNT_W'(found && (c != INT_CAT));
         assign pick_vld[c]  = found;
         assign pick_wave[c] = idx;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt_vld   <= '0;
         gnt_simd  <= '0;
         gnt_wave  <= '0;
         issue_cnt <= '0;
      end else begin
         gnt_vld   <= pick_vld;
         issue_cnt <= g_cat[NUM_CAT-1].nint_out;
         for (int c = 0; c < NUM_CAT; c++) begin
            gnt_simd[c*SIMD_W +: SIMD_W] <= pick_vld[c] ? rot : '0;
            gnt_wave[c*WAVE_W +: WAVE_W] <= pick_vld[c] ? pick_wave[c] : '0;
         end
      end
   end

   // ---------------- checks on the registered grants ----------------
   logic dup_wave;
   always_comb begin
      dup_wave = 1'b0;
      for (int a = 0; a < NUM_CAT; a++)
         for (int b = a + 1; b < NUM_CAT; b++)
            if (gnt_vld[a] && gnt_vld[b] &&
                gnt_wave[a*WAVE_W +: WAVE_W] == gnt_wave[b*WAVE_W +: WAVE_W])
               dup_wave = 1'b1;
   end

   // R6
   one_per_wave_chk: assert property (@(posedge clk) disable iff (rst) !dup_wave);

   // R9
   issue_cap_chk: assert property (@(posedge clk) disable iff (rst)
      int'(issue_cnt) <= MAX_ISSUE);

   // R11
   cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
      int'(issue_cnt) == $countones(gnt_vld) - int'(gnt_vld[INT_CAT]));

   generate
      for (genvar c = 0; c < NUM_CAT; c++) begin : g_simd_chk
         // R2
         simd_match_chk: assert property (@(posedge clk) disable iff (rst)
            gnt_vld[c] |-> gnt_simd[c*SIMD_W +: SIMD_W] == $past(rot));
      end
   endgenerate
endmodule

// File: tb/wave_issue_arbiter_tb.sv
`timescale 1ns/1ps
module wave_issue_arbiter_tb;
   localparam int NS = 4, W = 10, NC = 7, AW = 8, SLOTS = NS * W;

   logic clk = 1'b0, rst = 1'b1;
   logic [SLOTS*NC-1:0] slot_rdy;
   logic [SLOTS*AW-1:0] slot_age;
   logic [SLOTS-1:0]    slot_stall;
   logic [NC-1:0]       gnt_vld;
   logic [NC*2-1:0]     gnt_simd;
   logic [NC*4-1:0]     gnt_wave;
   logic [2:0]          issue_cnt;

   int compared = 0, mismatched = 0, cyc = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   wave_issue_arbiter u_dut (
      .clk(clk), .rst(rst), .slot_rdy(slot_rdy), .slot_age(slot_age),
      .slot_stall(slot_stall), .gnt_vld(gnt_vld), .gnt_simd(gnt_simd),
      .gnt_wave(gnt_wave), .issue_cnt(issue_cnt)
   );

   typedef struct packed {
      logic [3:0] wa; logic [6:0] ra; logic [7:0] aa;
      logic [3:0] wb; logic [6:0] rb; logic [7:0] ab;
      logic [2:0] cat; logic [3:0] wave; logic [6:0] mask; logic [2:0] cnt;
   } vec_t;

   // two active waves (replicated on every SIMD), expected grant of one category
   localparam vec_t VEC [7] = '{
      '{4'd2, 7'h01, 8'd5,   4'd7, 7'h01, 8'd9,   3'd0, 4'd7, 7'b0000001, 3'd1}, // R3
      '{4'd3, 7'h01, 8'd4,   4'd1, 7'h01, 8'd4,   3'd0, 4'd1, 7'b0000001, 3'd1}, // R4
      '{4'd4, 7'h11, 8'd9,   4'd6, 7'h10, 8'd2,   3'd4, 4'd6, 7'b0010001, 3'd2}, // R7
      '{4'd4, 7'h11, 8'd9,   4'd4, 7'h11, 8'd9,   3'd4, 4'd0, 7'b0000001, 3'd1}, // R6
      '{4'd0, 7'h40, 8'd1,   4'd9, 7'h02, 8'd3,   3'd6, 4'd0, 7'b1000010, 3'd1}, // R10
      '{4'd5, 7'h00, 8'd3,   4'd8, 7'h00, 8'd3,   3'd0, 4'd0, 7'b0000000, 3'd0}, // R5
      '{4'd8, 7'h04, 8'd3,   4'd2, 7'h04, 8'd250, 3'd2, 4'd2, 7'b0000100, 3'd1}  // R5
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_all();
      slot_rdy = '0; slot_age = '0; slot_stall = '0;
   endtask

   task automatic set_wave(input int w, input logic [6:0] r, input logic [7:0] a, input logic st);
      for (int s = 0; s < NS; s++) begin
         slot_rdy[(s*W + w)*NC +: NC] = r;
         slot_age[(s*W + w)*AW +: AW] = a;
         slot_stall[s*W + w]          = st;
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int wave_of(input int c);
      return int'(gnt_wave[c*4 +: 4]);
   endfunction

   function automatic int simd_of(input int c);
      return int'(gnt_simd[c*2 +: 2]);
   endfunction

   initial begin
      #(4 * 100000);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      clear_all();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1", "gnt_vld after reset", int'(gnt_vld), 0);
      check("R1", "issue_cnt after reset", int'(issue_cnt), 0);
      rst = 1'b0;

      for (int i = 0; i < 7; i++) begin
         clear_all();
         set_wave(int'(VEC[i].wa), VEC[i].ra, VEC[i].aa, 1'b0);
         set_wave(int'(VEC[i].wb), VEC[i].rb, VEC[i].ab, 1'b0);
         step();
         if (i == 0) check("R1", "first SIMD after reset", simd_of(0), 0);
         check("R5", "grant mask", int'(gnt_vld), int'(VEC[i].mask));
         check("R11", "issue count", int'(issue_cnt), int'(VEC[i].cnt));
         if (VEC[i].mask[VEC[i].cat]) begin
            check("R3", "winning wave", wave_of(int'(VEC[i].cat)), int'(VEC[i].wave));
            check("R2", "grant SIMD", simd_of(int'(VEC[i].cat)), (cyc - 1) % NS);
         end
      end

      // R9 R10: six non-internal categories plus internal, all ready
      clear_all();
      for (int c = 0; c < NC; c++) set_wave(c, 7'(1 << c), 8'd1, 1'b0);
      step();
      check("R9", "cap mask", int'(gnt_vld), 7'b1011111);
      check("R9", "cap count", int'(issue_cnt), 5);
      check("R10", "internal wave", wave_of(6), 6);

      // R9: export alone is not blocked
      clear_all();
      set_wave(0, 7'h20, 8'd1, 1'b0);
      step();
      check("R9", "export alone mask", int'(gnt_vld), 7'b0100000);

      // R8 stall removes the older wave
      clear_all();
      set_wave(7, 7'h01, 8'd200, 1'b1);
      set_wave(2, 7'h01, 8'd1, 1'b0);
      step();
      check("R8", "stalled wave skipped", wave_of(0), 2);
      // R12: new inputs do not change outputs before the edge
      set_wave(7, 7'h01, 8'd200, 1'b0);
      #1;
      check("R12", "output held before edge", wave_of(0), 2);
      step();
      check("R8", "unstalled wave wins", wave_of(0), 7);

      // R2 rotation: single request on SIMD 2 only
      clear_all();
      slot_rdy[(2*W + 3)*NC +: NC] = 7'h01;
      for (int k = 0; k < 8; k++) begin
         step();
         check("R2", "grant only on SIMD 2", int'(gnt_vld[0]), ((cyc - 1) % NS == 2) ? 1 : 0);
         if (gnt_vld[0]) begin
            check("R2", "SIMD index", simd_of(0), 2);
            check("R2", "wave index", wave_of(0), 3);
         end
      end

      // R1 mid-run reset restarts rotation at SIMD 0
      clear_all();
      set_wave(5, 7'h01, 8'd7, 1'b0);
      rst = 1'b1;
      step();
      check("R1", "gnt_vld during reset", int'(gnt_vld), 0);
      rst = 1'b0;
      step();
      check("R1", "SIMD after re-reset", simd_of(0), 0);
      check("R1", "wave after re-reset", wave_of(0), 5);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule